// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block sits beside a parallel flash array and watches the host's write cycles. It recognises multi-write command sequences and turns each completed sequence into a single-cycle strobe for the array engine. A program strobe carries the captured address and data. A chip-erase strobe carries no arguments. A sector-erase strobe carries the sector number. Writes that do not complete a known sequence produce nothing. The array, the embedded program and erase algorithms and any high-voltage behaviour are left to other blocks.

Besides the normal unlocked sequences, the interpreter has a sticky fast-program mode. Once this mode is on, the unlock prefix is no longer needed and a program takes only two writes. In this mode only two sequences are legal: the short program and the two-write mode exit. The mode is entered by command, or it is forced on for as long as the acceleration input is held high. The current mode is reported on `bypass_mode`.

All write decoding happens on the rising clock edge at which `wr_en` is high. Strobes appear in the cycle after the write that completes a sequence.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Three writes enter fast-program mode: data AAh at an address whose low 11 bits are 555h, then data 55h at low bits 2AAh, then data 20h. `bypass_mode` is 1 from the cycle after the third write. Address bits above bit 10 are not compared.
- R2: In fast-program mode, a write of data A0h followed by any second write gives `prog_stb` high for one cycle, in the cycle after the second write. `prog_addr` and `prog_data` then equal that second write's address and data. The pair may repeat any number of times with no unlock prefix.
- R3: In fast-program mode, a write other than A0h or 90h, given while no program or exit sequence is in progress, produces no strobe and leaves `bypass_mode` at 1. This includes unlock, 20h, 80h, 10h and 30h writes.
- R4: In fast-program mode, data 90h followed by data 00h clears `bypass_mode` in the cycle after the 00h write. If the write after 90h is not 00h, the mode stays on and the interpreter waits again for A0h or 90h.
- R5: While `accel` is 1, `bypass_mode` is 1 in the same cycle, and the two-write program of R2 is accepted at once.
- R6: When `accel` falls and the mode was not entered by command, `bypass_mode` drops in the same cycle. Any partly written fast-program sequence is discarded. If the mode was entered by command, it stays on.
- R7: Chip erase: the two unlock writes of R1, then 80h, then the two unlock writes again, then 10h. Outside fast-program mode this gives `chip_erase_stb` high for exactly one cycle, in the cycle after the sixth write.
- R8: Sector erase uses the same five-write prefix as R7, with 30h as the sixth write. It gives `sect_erase_stb` for one cycle, and `sect_addr` equals bits [19:15] of the sixth write's address.
- R9: Outside fast-program mode, any write that is not the expected next write of a sequence returns the interpreter to idle. A later write that would have continued the sequence then has no effect.
- R10: A synchronous active-high `rst` clears command-entered fast-program mode, any partial sequence and all strobes by the next cycle.
- R11: At most one strobe is high in any cycle, and cycles with `wr_en` low never advance a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write cycle qualifier |
| wr_addr | input | 20 | Write word address |
| wr_data | input | 8 | Write data / command code |
| accel | input | 1 | Acceleration level, forces fast-program mode |
| prog_stb | output | 1 | One-cycle program command |
| prog_addr | output | 20 | Program target address |
| prog_data | output | 8 | Program data |
| chip_erase_stb | output | 1 | One-cycle chip-erase command |
| sect_erase_stb | output | 1 | One-cycle sector-erase command |
| sect_addr | output | 5 | Sector number for sector erase |
| bypass_mode | output | 1 | Fast-program mode active |

## Verification
Mode changes from the `accel` level can land in the same cycle as a write that continues a sequence. Examples are `accel` rising with the sixth write of an erase, or `accel` falling with the data write of a fast program. The bench provokes both on purpose in directed cases. It also toggles `accel` at random under constrained random write traffic that is biased toward command codes and unlock addresses. Each cycle is judged against a bench model written from the requirements: a write takes the mode that holds in its own cycle, so an erase completed while `accel` rises must not strobe, and a program data write while `accel` falls must not strobe.

// File: rtl/fcsi_pkg.sv
package fcsi_pkg;

    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] K_UNLOCK_A  = 8'hAA;
    localparam logic [CODE_W-1:0] K_UNLOCK_B  = 8'h55;
    localparam logic [CODE_W-1:0] K_FAST_ON   = 8'h20;
    localparam logic [CODE_W-1:0] K_ERASE_SET = 8'h80;
    localparam logic [CODE_W-1:0] K_ERASE_ALL = 8'h10;
    localparam logic [CODE_W-1:0] K_ERASE_SEC = 8'h30;
    localparam logic [CODE_W-1:0] K_FAST_PROG = 8'hA0;
    localparam logic [CODE_W-1:0] K_FAST_OFF1 = 8'h90;
    localparam logic [CODE_W-1:0] K_FAST_OFF2 = 8'h00;

    localparam int          UNL_ABITS = 11;
    localparam logic [10:0] K_ADR_A   = 11'h555;
    localparam logic [10:0] K_ADR_B   = 11'h2AA;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_ESETUP,
        ST_EUNL1,
        ST_EUNL2,
        ST_FP_IDLE,
        ST_FP_DATA,
        ST_FP_OFF
    } seq_st_e;

    typedef struct packed {
        logic unl_a;
        logic unl_b;
        logic fast_on;
        logic erase_set;
        logic erase_all;
        logic erase_sec;
        logic fast_prog;
        logic fast_off1;
        logic fast_off2;
    } wr_class_t;

    function automatic logic is_fast_state(input seq_st_e s);
        return (s == ST_FP_IDLE) || (s == ST_FP_DATA) || (s == ST_FP_OFF);
    endfunction

endpackage

// File: rtl/fcsi_classify.sv
module fcsi_classify
    import fcsi_pkg::*;
(
    input  logic [UNL_ABITS-1:0] adr_low,
    input  logic [CODE_W-1:0]    code,
    output wr_class_t            cls
);
    always_comb begin
        cls           = '0;
        cls.unl_a     = (adr_low == K_ADR_A) && (code == K_UNLOCK_A);
        cls.unl_b     = (adr_low == K_ADR_B) && (code == K_UNLOCK_B);
        cls.fast_on   = (code == K_FAST_ON);
        cls.erase_set = (code == K_ERASE_SET);
        cls.erase_all = (code == K_ERASE_ALL);
        cls.erase_sec = (code == K_ERASE_SEC);
        cls.fast_prog = (code == K_FAST_PROG);
        cls.fast_off1 = (code == K_FAST_OFF1);
        cls.fast_off2 = (code == K_FAST_OFF2);
    end
endmodule

// File: rtl/fcsi_mode.sv
module fcsi_mode (
    input  logic clk,
    input  logic rst,
    input  logic accel,
    input  logic set_cmd,
    input  logic clr_cmd,
    output logic bypass
);
    logic cmd_q;

    always_ff @(posedge clk) begin
        if (rst)          cmd_q <= 1'b0;
        else if (set_cmd) cmd_q <= 1'b1;
        else if (clr_cmd) cmd_q <= 1'b0;
    end

    assign bypass = cmd_q | accel;

    AST_SET_ONLY_NORMAL: assert property (@(posedge clk) disable iff (rst)
        set_cmd |-> !bypass); // R1
    AST_CLR_ONLY_FAST: assert property (@(posedge clk) disable iff (rst)
        clr_cmd |-> bypass); // R4
endmodule

// File: rtl/fcsi_seq.sv
module fcsi_seq
    import fcsi_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 8,
    parameter int SECT_LSB = 15,
    localparam int SECT_W  = ADDR_W - SECT_LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  wr_class_t         cls,
    input  logic              bypass,
    output logic              set_cmd,
    output logic              clr_cmd,
    output logic              prog_stb,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              chip_stb,
    output logic              sect_stb,
    output logic [SECT_W-1:0] sect_addr
);
    seq_st_e st_q, st_eff, st_d;
    logic    fire_prog, fire_chip, fire_sect;

    always_comb begin
        st_eff = st_q;
        if (bypass && !is_fast_state(st_q))      st_eff = ST_FP_IDLE;
        else if (!bypass && is_fast_state(st_q)) st_eff = ST_READ;

        st_d      = st_eff;
        set_cmd   = 1'b0;
        clr_cmd   = 1'b0;
        fire_prog = 1'b0;
        fire_chip = 1'b0;
        fire_sect = 1'b0;

        if (wr_en) begin
            unique case (st_eff)
                ST_READ:   st_d = cls.unl_a ? ST_UNL1 : ST_READ;
                ST_UNL1:   st_d = cls.unl_b ? ST_UNL2 : ST_READ;
                ST_UNL2: begin
                    if (cls.fast_on) begin
                        set_cmd = 1'b1;
                        st_d    = ST_FP_IDLE;
                    end else if (cls.erase_set) begin
                        st_d = ST_ESETUP;
                    end else begin
                        st_d = ST_READ;
                    end
                end
                ST_ESETUP: st_d = cls.unl_a ? ST_EUNL1 : ST_READ;
                ST_EUNL1:  st_d = cls.unl_b ? ST_EUNL2 : ST_READ;
                ST_EUNL2: begin
                    fire_chip = cls.erase_all;
                    fire_sect = cls.erase_sec;
                    st_d      = ST_READ;
                end
                ST_FP_IDLE: begin
                    if (cls.fast_prog)      st_d = ST_FP_DATA;
                    else if (cls.fast_off1) st_d = ST_FP_OFF;
                    else                    st_d = ST_FP_IDLE;
                end
                ST_FP_DATA: begin
                    fire_prog = 1'b1;
                    st_d      = ST_FP_IDLE;
                end
                ST_FP_OFF: begin
                    if (cls.fast_off2) begin
                        clr_cmd = 1'b1;
                        st_d    = ST_READ;
                    end else begin
                        st_d = ST_FP_IDLE;
                    end
                end
                default:   st_d = ST_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_READ;
            prog_stb <= 1'b0;
            chip_stb <= 1'b0;
            sect_stb <= 1'b0;
        end else begin
            st_q     <= st_d;
            prog_stb <= fire_prog;
            chip_stb <= fire_chip;
            sect_stb <= fire_sect;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_addr <= '0;
            prog_data <= '0;
            sect_addr <= '0;
        end else begin
            if (fire_prog) begin
                prog_addr <= wr_addr;
                prog_data <= wr_data;
            end
            if (fire_sect) sect_addr <= wr_addr[ADDR_W-1:SECT_LSB];
        end
    end

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !(prog_stb || chip_stb || sect_stb)); // R11
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcsi_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 8,
    parameter int SECT_LSB = 15,
    localparam int SECT_W  = ADDR_W - SECT_LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              accel,
    output logic              prog_stb,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              chip_erase_stb,
    output logic              sect_erase_stb,
    output logic [SECT_W-1:0] sect_addr,
    output logic              bypass_mode
);
    wr_class_t cls;
    logic      set_cmd, clr_cmd;

    fcsi_classify u_cls (
        .adr_low (wr_addr[UNL_ABITS-1:0]),
        .code    (wr_data[CODE_W-1:0]),
        .cls     (cls)
    );

    fcsi_mode u_mode (
        .clk     (clk),
        .rst     (rst),
        .accel   (accel),
        .set_cmd (set_cmd),
        .clr_cmd (clr_cmd),
        .bypass  (bypass_mode)
    );

    fcsi_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SECT_LSB (SECT_LSB)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cls       (cls),
        .bypass    (bypass_mode),
        .set_cmd   (set_cmd),
        .clr_cmd   (clr_cmd),
        .prog_stb  (prog_stb),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .chip_stb  (chip_erase_stb),
        .sect_stb  (sect_erase_stb),
        .sect_addr (sect_addr)
    );

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({prog_stb, chip_erase_stb, sect_erase_stb})); // R11
    AST_PROG_IN_FAST: assert property (@(posedge clk) disable iff (rst)
        prog_stb |-> $past(bypass_mode && wr_en)); // R2
    AST_ERASE_IN_NORMAL: assert property (@(posedge clk) disable iff (rst)
        (chip_erase_stb || sect_erase_stb) |-> $past(!bypass_mode && wr_en)); // R7
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !(prog_stb || chip_erase_stb || sect_erase_stb)); // R10
endmodule

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        accel = 1'b0;
    logic        prog_stb, chip_erase_stb, sect_erase_stb, bypass_mode;
    logic [19:0] prog_addr;
    logic [7:0]  prog_data;
    logic [4:0]  sect_addr;

    always #2.5 clk = ~clk;

    flash_cmd_decoder dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .accel(accel), .prog_stb(prog_stb),
        .prog_addr(prog_addr), .prog_data(prog_data),
        .chip_erase_stb(chip_erase_stb), .sect_erase_stb(sect_erase_stb),
        .sect_addr(sect_addr), .bypass_mode(bypass_mode)
    );

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R10";

    // bench model: 0 idle,1..5 unlock/erase steps,10 fast idle,11 fast data,12 fast exit
    int          m_st = 0;
    bit          m_cmd = 0;
    bit          m_prog = 0, m_chip = 0, m_sect = 0;
    logic [19:0] m_paddr = '0;
    logic [7:0]  m_pdata = '0;
    logic [4:0]  m_saddr = '0;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("bypass_mode", 32'(bypass_mode), 32'(m_cmd | accel));
        chk("prog_stb", 32'(prog_stb), 32'(m_prog));
        chk("chip_erase_stb", 32'(chip_erase_stb), 32'(m_chip));
        chk("sect_erase_stb", 32'(sect_erase_stb), 32'(m_sect));
        if (m_prog) begin
            chk("prog_addr", 32'(prog_addr), 32'(m_paddr));
            chk("prog_data", 32'(prog_data), 32'(m_pdata));
        end
        if (m_sect) chk("sect_addr", 32'(sect_addr), 32'(m_saddr));
    endtask

    function automatic bit is_a(input logic [19:0] a, input logic [7:0] d);
        return (a[10:0] == 11'h555) && (d == 8'hAA);
    endfunction
    function automatic bit is_b(input logic [19:0] a, input logic [7:0] d);
        return (a[10:0] == 11'h2AA) && (d == 8'h55);
    endfunction

    task automatic model(input bit we, input logic [19:0] a, input logic [7:0] d,
                         input bit acc, input bit r);
        int s;
        m_prog = 0; m_chip = 0; m_sect = 0;
        if (r) begin
            m_st = 0; m_cmd = 0;
            return;
        end
        s = m_st;
        if ((m_cmd | acc) && s < 10) s = 10;
        if (!(m_cmd | acc) && s >= 10) s = 0;
        if (we) begin
            case (s)
                0: s = is_a(a, d) ? 1 : 0;
                1: s = is_b(a, d) ? 2 : 0;
                2: if (d == 8'h20) begin m_cmd = 1; s = 10; end
                   else s = (d == 8'h80) ? 3 : 0;
                3: s = is_a(a, d) ? 4 : 0;
                4: s = is_b(a, d) ? 5 : 0;
                5: begin
                    m_chip = (d == 8'h10);
                    m_sect = (d == 8'h30);
                    if (m_sect) m_saddr = a[19:15];
                    s = 0;
                end
                10: s = (d == 8'hA0) ? 11 : (d == 8'h90) ? 12 : 10;
                11: begin m_prog = 1; m_paddr = a; m_pdata = d; s = 10; end
                12: if (d == 8'h00) begin m_cmd = 0; s = 0; end else s = 10;
                default: s = 0;
            endcase
        end
        m_st = s;
    endtask

    task automatic step(input bit we, input logic [19:0] a, input logic [7:0] d,
                        input bit acc, input bit r);
        @(negedge clk);
        compare();
        wr_en = we; wr_addr = a; wr_data = d; accel = acc; rst = r;
        model(we, a, d, acc, r);
    endtask

    task automatic wr(input logic [19:0] a, input logic [7:0] d);
        step(1, a, d, accel, 0);
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, wr_addr, wr_data, accel, 0);
    endtask
    task automatic unlock(input logic [8:0] hi);
        wr({hi, 11'h555}, 8'hAA);
        wr({hi, 11'h2AA}, 8'h55);
    endtask

    function automatic logic [7:0] pick_code();
        case ($urandom_range(0, 10))
            0: return 8'hAA;  1: return 8'h55;  2: return 8'h20;
            3: return 8'h80;  4: return 8'h10;  5: return 8'h30;
            6: return 8'hA0;  7: return 8'h90;  8: return 8'h00;
            default: return 8'($urandom);
        endcase
    endfunction

    bit done = 0;
    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        cur_req = "R10";
        step(0, '0, '0, 0, 1);
        step(0, '0, '0, 0, 1);
        step(0, '0, '0, 0, 0);
        idle(2);

        cur_req = "R1";  unlock(9'h1A3); wr(20'h00000, 8'h20); idle(2);
        cur_req = "R2";  wr(20'h12345, 8'hA0); wr(20'hABCDE, 8'h5A);
                         wr(20'h00001, 8'hA0); wr(20'hFFFFF, 8'hA0); idle(2);
        cur_req = "R3";  unlock(9'h0); wr(20'h0, 8'h20); wr(20'h0, 8'h80);
                         wr(20'h0, 8'h10); wr(20'h0, 8'h30); idle(2);
        cur_req = "R4";  wr(20'h0, 8'h90); wr(20'h0, 8'h01); wr(20'h0, 8'hA0);
                         wr(20'h00777, 8'h3C); wr(20'h0, 8'h90); wr(20'h0, 8'h00); idle(2);
        cur_req = "R7";  unlock(9'h055); wr(20'h0, 8'h80); unlock(9'h0);
                         wr(20'h0, 8'h10); idle(2);
        cur_req = "R8";  unlock(9'h0); wr(20'h0, 8'h80); unlock(9'h1FF);
                         wr(20'hB8000, 8'h30); idle(2);
        cur_req = "R9";  unlock(9'h0); wr(20'h0, 8'h80); wr(20'h00555, 8'hAB);
                         wr(20'h002AA, 8'h55); wr(20'h0, 8'h10);
                         wr(20'h00554, 8'hAA); wr(20'h002AA, 8'h55); wr(20'h0, 8'h20); idle(2);
        cur_req = "R5";  step(0, '0, '0, 1, 0); wr(20'h0, 8'hA0); wr(20'h4321F, 8'hC3); idle(2);
        cur_req = "R6";  wr(20'h0, 8'hA0); step(1, 20'h11111, 8'h77, 0, 0); idle(2);
                         unlock(9'h0); wr(20'h0, 8'h20); step(0, '0, '0, 1, 0);
                         step(0, '0, '0, 0, 0); wr(20'h0, 8'hA0); wr(20'h22222, 8'h99);
                         wr(20'h0, 8'h90); wr(20'h0, 8'h00); idle(2);
        // accel rising together with the sixth erase write: must not erase
        cur_req = "R5";  unlock(9'h0); wr(20'h0, 8'h80); unlock(9'h0);
                         step(1, 20'h0, 8'h10, 1, 0); step(0, '0, '0, 0, 0); idle(2);
        cur_req = "R10"; unlock(9'h0); wr(20'h0, 8'h20); wr(20'h0, 8'hA0);
                         step(1, 20'h3, 8'h4, 0, 1); idle(2);
        cur_req = "R11"; unlock(9'h0); step(0, '0, '0, 0, 0); wr(20'h0, 8'h80); idle(2);

        cur_req = "R11";
        for (int i = 0; i < 4000; i++) begin
            logic [19:0] a;
            bit acc;
            a = 20'($urandom);
            case ($urandom_range(0, 3))
                0: a[10:0] = 11'h555;
                1: a[10:0] = 11'h2AA;
                default: ;
            endcase
            acc = accel;
            if ($urandom_range(0, 40) == 0) acc = ~accel;
            step($urandom_range(0, 5) != 0, a, pick_code(), acc,
                 $urandom_range(0, 300) == 0);
        end
        step(0, '0, '0, 0, 0);
        idle(2);
        finish_run();
    end
endmodule